// File: doc/BRIEF.md
# Four-Digit Adding Calculator Controller

A synchronous controller for a keypad adding calculator. A key press arrives as a 4-bit code with a one-cycle strobe. Digit keys build an entry value, the add key folds the entry into a running accumulator, the equals key folds in the last entry and shows the total, and the clear key returns everything to zero. The controller drives a four-position display through a 16-bit bus. Each 4-bit group is the character code for one position, and the most significant group is the leftmost position.

Both the entry and the accumulator are kept as four BCD digits. Each display group is therefore a decimal digit taken directly from a register. Leading zeros are turned into blanks. A sum larger than 9999 locks the controller into an error display that only the clear key, or reset, can leave.

Top module: `addcalc_ctrl`

## Requirements
- R1: After reset (rst_n low, asynchronous), and while it is held, the display bus reads 16'hFFF0: three blanks (code 15) and a '0'.
- R2: Digit keys (codes 0–9) shift a new decimal digit into the entry from the right. The display shows the entry, with leading zeros shown as blank (code 15). The bus holds only character codes 0–9, 14 or 15.
- R3: A digit pressed while the entry already holds four significant digits is ignored.
- R4: The add key (code 10) adds the entry to the accumulator and shows the running sum. The next digit key starts a fresh entry, and the accumulator is kept.
- R5: The equals key (code 11) adds the pending entry and shows the total. A digit key after equals starts a new calculation with the accumulator at zero. An add key after equals continues from the total.
- R6: A sum above 9999 shows 16'hFFFE (three blanks and 'E', code 14). A sum of exactly 9999 is shown normally.
- R7: In the error state, every key other than clear leaves the display at 16'hFFFE.
- R8: The clear key (code 12) returns the controller to its reset state from any state, and the display reads 16'hFFF0 in the next cycle.
- R9: Nothing changes while key_vld is low. Key codes 13–15 have no effect.
- R10: A zero digit pressed on an empty entry does not count as a significant digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_vld | input | 1 | Key strobe, high for one cycle per press |
| key_code | input | 4 | Key code: 0–9 digits, 10 add, 11 equals, 12 clear |
| disp | output | 16 | Four character codes, leftmost position in bits 15:12 |

## Verification
The hardest case to reach from the ports is a carry out of the top BCD digit. Getting there takes two four-digit operands that are built digit by digit and pass through the accumulator. The stimulus table first builds 1250 as a running total, then enters 8765 and presses equals to overflow. Further rows test keys while the error lock is active, then assemble 4000 + 5999 to hit exactly 9999 and push it over with one more unit. Rows where equals is followed by a digit, and rows with a digit after add, tell the two accumulator-retention rules apart by the sums they produce.

// File: rtl/addcalc_ctrl.sv
module addcalc_ctrl #(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_vld,
  input  logic [3:0]        key_code,
  output logic [4*NDIG-1:0] disp
);
  localparam int W  = 4 * NDIG;
  localparam int CW = $clog2(NDIG + 1);
  localparam logic [3:0] K_ADD = 4'd10, K_EQ = 4'd11, K_CLR = 4'd12;
  localparam logic [3:0] CH_ERR = 4'd14, CH_BLANK = 4'd15;

  logic [W-1:0]  entry, acc, sum, shown;
  logic [CW-1:0] cnt;
  logic          err, show_acc, eq_done, sum_ovf;
  logic          carry, lead;
  logic [4:0]    dsum;
  logic [3:0]    dch;

  wire is_digit = key_code <= 4'd9;
  wire is_op    = (key_code == K_ADD) || (key_code == K_EQ);
  wire take_dig = !(cnt == '0 && key_code == 4'd0) && cnt != CW'(NDIG);

  always_comb begin
    carry = 1'b0;
    sum   = '0;
    dsum  = '0;
    for (int i = 0; i < NDIG; i++) begin
      dsum = {1'b0, acc[4*i +: 4]} + {1'b0, entry[4*i +: 4]} + {4'd0, carry};
      if (dsum > 5'd9) begin
        dsum  = dsum - 5'd10;
        carry = 1'b1;
      end else begin
        carry = 1'b0;
      end
      sum[4*i +: 4] = dsum[3:0];
    end
    sum_ovf = carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry <= '0; acc <= '0; cnt <= '0;
      err <= 1'b0; show_acc <= 1'b0; eq_done <= 1'b0;
    end else if (key_vld && key_code == K_CLR) begin
      entry <= '0; acc <= '0; cnt <= '0;
      err <= 1'b0; show_acc <= 1'b0; eq_done <= 1'b0;
    end else if (key_vld && !err) begin
      if (is_digit) begin
        show_acc <= 1'b0;
        if (eq_done) begin
          acc     <= '0;
          eq_done <= 1'b0;
        end
        if (take_dig) begin
          entry <= {entry[W-5:0], key_code};
          cnt   <= cnt + 1'b1;
        end
      end else if (is_op) begin
        if (sum_ovf) err <= 1'b1;
        else         acc <= sum;
        entry    <= '0;
        cnt      <= '0;
        show_acc <= 1'b1;
        eq_done  <= (key_code == K_EQ);
      end
    end
  end

  assign shown = show_acc ? acc : entry;

  always_comb begin
    lead = 1'b1;
    disp = '0;
    dch  = '0;
    for (int i = NDIG - 1; i >= 0; i--) begin
      dch = shown[4*i +: 4];
      if (lead && dch == 4'd0 && i != 0) begin
        disp[4*i +: 4] = CH_BLANK;
      end else begin
        lead = 1'b0;
        disp[4*i +: 4] = dch;
      end
    end
    if (err) disp = {{(NDIG-1){CH_BLANK}}, CH_ERR};
  end
endmodule

module addcalc_ctrl_chk #(
  parameter int NDIG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_vld,
  input logic [3:0]        key_code,
  input logic [4*NDIG-1:0] disp
);
  localparam logic [4*NDIG-1:0] ERR_PAT = {{(NDIG-1){4'hF}}, 4'hE};
  localparam logic [4*NDIG-1:0] CLR_PAT = {{(NDIG-1){4'hF}}, 4'h0};

  a_r8_clear_next: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld && key_code == 4'd12 |=> disp == CLR_PAT);

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !key_vld |=> $stable(disp));

  a_r7_err_locked: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld && key_code != 4'd12 && disp == ERR_PAT |=> disp == ERR_PAT);

  a_r9_unused_codes: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld && key_code > 4'd12 |=> $stable(disp));

  for (genvar g = 0; g < NDIG; g++) begin : g_chars
    a_r2_charset: assert property (@(posedge clk) disable iff (!rst_n)
      disp[4*g +: 4] <= 4'd9 || disp[4*g +: 4] >= 4'd14);
  end
endmodule

bind addcalc_ctrl addcalc_ctrl_chk #(.NDIG(NDIG)) u_chk (.*);

// File: tb/test_addcalc_ctrl.sv
`timescale 1ns/1ps
module test_addcalc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_vld = 1'b0;
  logic [3:0]  key_code = 4'd0;
  logic [15:0] disp;
  int          errors = 0;
  int          checks = 0;

  addcalc_ctrl i_addcalc_ctrl (.clk(clk), .rst_n(rst_n), .key_vld(key_vld),
                               .key_code(key_code), .disp(disp));

  always #2.5 clk = ~clk;

  localparam int NV = 43;
  // {requirement, key code, expected display}
  localparam logic [23:0] VEC [NV] = '{
    {4'd8, 4'd12, 16'hFFF0},  // R8
    {4'd2, 4'd1,  16'hFFF1},  // R2
    {4'd2, 4'd2,  16'hFF12},
    {4'd2, 4'd3,  16'hF123},
    {4'd2, 4'd4,  16'h1234},
    {4'd3, 4'd5,  16'h1234},  // R3 fifth digit
    {4'd4, 4'd10, 16'h1234},  // R4
    {4'd4, 4'd9,  16'hFFF9},
    {4'd4, 4'd10, 16'h1243},
    {4'd10, 4'd0, 16'hFFF0},  // R10
    {4'd10, 4'd7, 16'hFFF7},
    {4'd5, 4'd11, 16'h1250},  // R5
    {4'd4, 4'd10, 16'h1250},
    {4'd2, 4'd8,  16'hFFF8},
    {4'd2, 4'd7,  16'hFF87},
    {4'd2, 4'd6,  16'hF876},
    {4'd2, 4'd5,  16'h8765},
    {4'd6, 4'd11, 16'hFFFE},  // R6 overflow
    {4'd7, 4'd3,  16'hFFFE},  // R7
    {4'd7, 4'd10, 16'hFFFE},
    {4'd7, 4'd13, 16'hFFFE},
    {4'd8, 4'd12, 16'hFFF0},
    {4'd2, 4'd5,  16'hFFF5},
    {4'd5, 4'd11, 16'hFFF5},
    {4'd5, 4'd2,  16'hFFF2},
    {4'd5, 4'd10, 16'hFFF2},
    {4'd9, 4'd15, 16'hFFF2},  // R9
    {4'd2, 4'd9,  16'hFFF9},
    {4'd5, 4'd11, 16'hFF11},
    {4'd8, 4'd12, 16'hFFF0},
    {4'd2, 4'd4,  16'hFFF4},
    {4'd2, 4'd0,  16'hFF40},
    {4'd2, 4'd0,  16'hF400},
    {4'd2, 4'd0,  16'h4000},
    {4'd4, 4'd10, 16'h4000},
    {4'd2, 4'd5,  16'hFFF5},
    {4'd2, 4'd9,  16'hFF59},
    {4'd2, 4'd9,  16'hF599},
    {4'd2, 4'd9,  16'h5999},
    {4'd6, 4'd11, 16'h9999},
    {4'd6, 4'd10, 16'h9999},
    {4'd2, 4'd1,  16'hFFF1},
    {4'd6, 4'd11, 16'hFFFE}
  };

  task automatic check(input int req, input logic [15:0] exp);
    checks++;
    if (disp !== exp) begin
      errors++;
      $display("FAIL R%0d: disp=%h expected=%h", req, disp, exp);
    end
  endtask

  task automatic press(input logic [3:0] code);
    @(negedge clk);
    key_vld  = 1'b1;
    key_code = code;
    @(negedge clk);
    key_vld  = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 16'hFFF0);           // R1 while in reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 16'hFFF0);           // R1 after release

    for (int n = 0; n < NV; n++) begin
      press(VEC[n][19:16]);
      check(int'(VEC[n][23:20]), VEC[n][15:0]);
    end

    press(4'd12);
    press(4'd7);
    check(2, 16'hFFF7);
    @(negedge clk);
    key_code = 4'd4;              // R9 code present, strobe low
    repeat (3) @(negedge clk);
    check(9, 16'hFFF7);

    press(4'd3);
    check(2, 16'hFF73);
    rst_n = 1'b0;                 // R1 reset mid-entry
    #1;
    check(1, 16'hFFF0);
    @(negedge clk);
    rst_n = 1'b1;
    press(4'd10);
    check(1, 16'hFFF0);           // R1 accumulator also cleared

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule